// File: doc/BRIEF.md
# Tank Fill Pump Interlock

This block is a clocked interlock controller for a single feed pump that can fill either of two tanks. It holds one fill memory per tank, which drives that tank's valve solenoid, and one run memory for the pump. A three-position selector chooses between off, manual and automatic operation. The block watches valve position switches, tank high-level switches, suction and seal-water pressure switches, the motor overload contact and a control-power-good flag. A slow tick, nominally once per second, times the suction-pressure trip.

In manual operation the pump starts when the selector is moved into the manual position, provided no trouble is present. In automatic operation a tank fill start both opens that tank's valve and arms a pump start request. The pump then runs once exactly one valve reads fully open and the other reads fully closed, and all other permissives hold. Every stop path overrides every start path. After any stop the pump waits for a fresh request before it runs again. The lamps and the alarm follow the state directly and have no effect on the control.

The selector is encoded as 00 = off, 01 = manual, 10 = automatic and 11 = off. The block has no data stream, so all pins are plain level control and status signals, with no handshake.

Top module: `pump_interlock_top`

## Requirements
- R1: The fill memory of tank i is set by `fill_start[i]` and cleared by `fill_stop[i]`. Stop wins when both are high together. `sol_energize[i]` is low while the memory is set (valve fails open) and high while it is clear (valve closes). The output changes on the clock edge after the command.
- R2: After reset `pump_run` is 0 and `sol_energize` is 2'b11. While `ctrl_power_ok` is low, both fill memories and the run memory are cleared at the next clock edge.
- R3: In automatic mode a `fill_start` pulse arms a start request. `pump_run` rises at the first clock edge at which the request is already armed and all of these hold: exactly one valve is fully open with the other fully closed, the selected tank is not at high level, `suction_low` is 0, `overload` is 0, and the starter is not tripped.
- R4: In automatic mode `pump_run` clears at the next clock edge when the selected valve leaves fully open, when the other valve leaves fully closed, or when the selected tank's high-level switch is active.
- R5: When `suction_low` stays high without a break across TRIP_TICKS (default 5) `tick` pulses, the pump stops at the following clock edge, in any mode. A single cycle with `suction_low` low restarts the count, and a short low-pressure spell does not stop the pump.
- R6: `overload` stops the pump at the next clock edge and trips the starter. A `starter_reset` pulse is ignored while `overload` is high. Once `overload` is low, a pulse clears the trip. A tripped starter blocks any start.
- R7: A stop and a start presented in the same cycle give a stop. In automatic mode any `fill_stop` stops the pump and cancels an armed request.
- R8: `lamp_red` equals `pump_run` and `lamp_green` is its inverse. `lamp_high` mirrors `level_high`. `seal_alarm` mirrors `seal_low`, and low seal water never stops the pump.
- R9: Moving the selector into manual (01) from any other position arms a request. The pump runs one clock edge later if `suction_low`, `overload` and the starter trip are all clear. The off positions (00, 11) stop it at the next edge.
- R10: After any stop the pump does not restart when the permissives return. It needs a new request: a new `fill_start` in automatic mode, or a new entry into manual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second, for the suction timer |
| mode_sel | input | 2 | Selector: 00 off, 01 manual, 10 automatic, 11 off |
| fill_start | input | 2 | Momentary fill start, one bit per tank |
| fill_stop | input | 2 | Momentary fill stop, one bit per tank |
| valve_open | input | 2 | Valve fully-open switch per tank |
| valve_closed | input | 2 | Valve fully-closed switch per tank |
| level_high | input | 2 | Tank high-level switch per tank |
| suction_low | input | 1 | Pump suction pressure low |
| seal_low | input | 1 | Seal water pressure low |
| overload | input | 1 | Motor overload contact |
| starter_reset | input | 1 | Starter reset request |
| ctrl_power_ok | input | 1 | Control power healthy |
| pump_run | output | 1 | Pump run command |
| sol_energize | output | 2 | Valve solenoid drive per tank (1 = energized, valve closes) |
| lamp_red | output | 1 | Running lamp |
| lamp_green | output | 1 | Stopped lamp |
| lamp_high | output | 2 | High-level lamp per tank |
| seal_alarm | output | 1 | Low seal-water alarm |

## Verification
The hardest state to reach is the suction trip at its exact boundary. The count must span TRIP_TICKS ticks with pressure low throughout, and must not trip when one recovered cycle falls inside the window. The bench first runs the pump in manual mode, then holds `suction_low` high while it issues ticks one at a time. It breaks the window once after the fourth tick, runs a fresh window of four ticks that must not trip, and only then issues the fifth tick. A second subtle case is the ignored starter reset during overload. The bench makes this visible at the ports by re-entering manual mode afterwards and showing that the pump stays stopped until a reset is given with the overload clear.

// File: rtl/pump_ilk_pkg.sv
package pump_ilk_pkg;
  localparam int NTANK = 2;

  typedef enum logic [1:0] {
    SEL_OFF   = 2'b00,
    SEL_MAN   = 2'b01,
    SEL_AUTO  = 2'b10,
    SEL_SPARE = 2'b11
  } sel_e;
endpackage

// File: rtl/ilk_fill_latch.sv
module ilk_fill_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic start_cmd,
  input  logic stop_cmd,
  output logic sol_on
);
  logic filling;

  // Stop and power loss dominate the start command.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              filling <= 1'b0;
    else if (!pwr_ok)        filling <= 1'b0;
    else if (stop_cmd)       filling <= 1'b0;
    else if (start_cmd)      filling <= 1'b1;
  end

  // Energized solenoid holds the valve closed; filling de-energizes it.
  assign sol_on = ~filling;
endmodule

// File: rtl/ilk_suction_timer.sv
module ilk_suction_timer #(
  parameter int TRIP_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic suction_low,
  output logic trip
);
  localparam int CW = $clog2(TRIP_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TRIP_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!suction_low)         cnt <= '0;
    else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign trip = suction_low && (cnt == LIMIT);
endmodule

// File: rtl/ilk_starter_latch.sv
module ilk_starter_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic overload,
  input  logic reset_req,
  output logic starter_ok
);
  logic tripped;

  // Overload has priority, so a reset request cannot clear the trip while it persists.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tripped <= 1'b0;
    else if (overload)  tripped <= 1'b1;
    else if (reset_req) tripped <= 1'b0;
  end

  assign starter_ok = ~tripped;
endmodule

// File: rtl/ilk_run_ctrl.sv
module ilk_run_ctrl
  import pump_ilk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sel_e       mode,
  input  logic       start_any,
  input  logic       stop_any,
  input  logic [1:0] vopen,
  input  logic [1:0] vclosed,
  input  logic [1:0] level_high,
  input  logic       suction_low,
  input  logic       suction_trip,
  input  logic       overload,
  input  logic       starter_ok,
  input  logic       pwr_ok,
  output logic       run
);
  sel_e mode_q;
  logic pending;

  logic sel0, sel1, pattern_ok, sel_high;
  logic is_off, is_auto, is_man;
  logic start_evt, hard_stop, auto_stop, common_ok, perm, run_set;

  // Exclusive valve pattern picks the tank being filled.
  always_comb begin
    sel0       = vopen[0] & ~vclosed[0] & vclosed[1] & ~vopen[1];
    sel1       = vopen[1] & ~vclosed[1] & vclosed[0] & ~vopen[0];
    pattern_ok = sel0 | sel1;
    sel_high   = (sel0 & level_high[0]) | (sel1 & level_high[1]);
  end

  always_comb begin
    is_off  = (mode == SEL_OFF) || (mode == SEL_SPARE);
    is_auto = (mode == SEL_AUTO);
    is_man  = (mode == SEL_MAN);

    start_evt = (is_auto && start_any) || (is_man && mode_q != SEL_MAN);
    hard_stop = !pwr_ok || is_off || suction_trip || overload || (is_auto && stop_any);
    auto_stop = is_auto && (!pattern_ok || sel_high);

    common_ok = !suction_low && !overload && starter_ok;
    perm      = is_auto ? (common_ok && pattern_ok && !sel_high) : common_ok;
    run_set   = pending && perm && !auto_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SEL_OFF;
      pending <= 1'b0;
      run     <= 1'b0;
    end else begin
      mode_q <= mode;

      if (hard_stop)      pending <= 1'b0;
      else if (start_evt) pending <= 1'b1;
      else if (run_set)   pending <= 1'b0;

      if (hard_stop || auto_stop) run <= 1'b0;
      else if (run_set)           run <= 1'b1;
    end
  end
endmodule

// File: rtl/pump_interlock_top.sv
module pump_interlock_top
  import pump_ilk_pkg::*;
#(
  parameter int TRIP_TICKS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode_sel,
  input  logic [1:0] fill_start,
  input  logic [1:0] fill_stop,
  input  logic [1:0] valve_open,
  input  logic [1:0] valve_closed,
  input  logic [1:0] level_high,
  input  logic       suction_low,
  input  logic       seal_low,
  input  logic       overload,
  input  logic       starter_reset,
  input  logic       ctrl_power_ok,
  output logic       pump_run,
  output logic [1:0] sol_energize,
  output logic       lamp_red,
  output logic       lamp_green,
  output logic [1:0] lamp_high,
  output logic       seal_alarm
);
  logic suction_trip;
  logic starter_ok;
  sel_e mode;

  assign mode = sel_e'(mode_sel);

  for (genvar t = 0; t < NTANK; t++) begin : g_tank
    ilk_fill_latch u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_ok    (ctrl_power_ok),
      .start_cmd (fill_start[t]),
      .stop_cmd  (fill_stop[t]),
      .sol_on    (sol_energize[t])
    );
  end

  ilk_suction_timer #(.TRIP_TICKS(TRIP_TICKS)) u_suction (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .suction_low (suction_low),
    .trip        (suction_trip)
  );

  ilk_starter_latch u_starter (
    .clk        (clk),
    .rst_n      (rst_n),
    .overload   (overload),
    .reset_req  (starter_reset),
    .starter_ok (starter_ok)
  );

  ilk_run_ctrl u_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .start_any    (|fill_start),
    .stop_any     (|fill_stop),
    .vopen        (valve_open),
    .vclosed      (valve_closed),
    .level_high   (level_high),
    .suction_low  (suction_low),
    .suction_trip (suction_trip),
    .overload     (overload),
    .starter_ok   (starter_ok),
    .pwr_ok       (ctrl_power_ok),
    .run          (pump_run)
  );

  assign lamp_red   = pump_run;
  assign lamp_green = ~pump_run;
  assign lamp_high  = level_high;
  assign seal_alarm = seal_low;
endmodule

// File: rtl/pump_interlock_chk.sv
module pump_interlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic [1:0] fill_stop,
  input logic [1:0] valve_open,
  input logic [1:0] valve_closed,
  input logic [1:0] level_high,
  input logic       overload,
  input logic       ctrl_power_ok,
  input logic       pump_run,
  input logic [1:0] sol_energize
);
  logic pick0, pick1;
  assign pick0 = valve_open[0] && !valve_closed[0] && valve_closed[1] && !valve_open[1];
  assign pick1 = valve_open[1] && !valve_closed[1] && valve_closed[0] && !valve_open[0];

  AST_FILL_STOP_T0: assert property (@(posedge clk) disable iff (!rst_n)
    fill_stop[0] |=> sol_energize[0]); // R1
  AST_FILL_STOP_T1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_stop[1] |=> sol_energize[1]); // R1
  AST_POWER_LOSS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_power_ok |=> (!pump_run && sol_energize == 2'b11)); // R2
  AST_AUTO_HIGH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && ((pick0 && level_high[0]) || (pick1 && level_high[1]))) |=> !pump_run); // R4
  AST_AUTO_PATTERN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && !pick0 && !pick1) |=> !pump_run); // R4
  AST_OVERLOAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    overload |=> !pump_run); // R6
  AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_run) |-> $past(!overload && ctrl_power_ok && fill_stop == 2'b00)); // R7
  AST_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 || mode_sel == 2'b11) |=> !pump_run); // R9
endmodule

bind pump_interlock_top pump_interlock_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_sel      (mode_sel),
  .fill_stop     (fill_stop),
  .valve_open    (valve_open),
  .valve_closed  (valve_closed),
  .level_high    (level_high),
  .overload      (overload),
  .ctrl_power_ok (ctrl_power_ok),
  .pump_run      (pump_run),
  .sol_energize  (sol_energize)
);

// File: tb/test_pump_interlock_top.sv
module test_pump_interlock_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [1:0] fill_start = 2'b00, fill_stop = 2'b00;
  logic [1:0] valve_open = 2'b00, valve_closed = 2'b11, level_high = 2'b00;
  logic       suction_low = 1'b0, seal_low = 1'b0, overload = 1'b0;
  logic       starter_reset = 1'b0, ctrl_power_ok = 1'b1;
  logic       pump_run, lamp_red, lamp_green, seal_alarm;
  logic [1:0] sol_energize, lamp_high;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pump_interlock_top i_pump_interlock_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
    .fill_start(fill_start), .fill_stop(fill_stop), .valve_open(valve_open),
    .valve_closed(valve_closed), .level_high(level_high), .suction_low(suction_low),
    .seal_low(seal_low), .overload(overload), .starter_reset(starter_reset),
    .ctrl_power_ok(ctrl_power_ok), .pump_run(pump_run), .sol_energize(sol_energize),
    .lamp_red(lamp_red), .lamp_green(lamp_green), .lamp_high(lamp_high),
    .seal_alarm(seal_alarm)
  );

  // Vector: mode, fill_start, fill_stop, valve_open, valve_closed, level_high,
  //         suction_low, overload, starter_reset, ctrl_power_ok, seal_low |
  //         expected pump_run, sol_energize, seal_alarm
  localparam int NV = 34;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0,2'b00,2'b00,2'b00,2'b11,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 0  R2 idle
    {2'd2,2'b01,2'b00,2'b00,2'b11,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b10,1'b0}, // 1  R1 fill start
    {2'd2,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,2'b10,1'b0}, // 2  R3 auto run
    {2'd2,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1,2'b10,1'b1}, // 3  R8 seal no trip
    {2'd2,2'b00,2'b00,2'b01,2'b10,2'b01,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b10,1'b0}, // 4  R4 high level
    {2'd2,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b10,1'b0}, // 5  R10 no restart
    {2'd2,2'b01,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b10,1'b0}, // 6  R10 request arms
    {2'd2,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,2'b10,1'b0}, // 7  R3 runs
    {2'd2,2'b00,2'b00,2'b00,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b10,1'b0}, // 8  R4 left open
    {2'd2,2'b01,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b10,1'b0}, // 9  R3 re-arm
    {2'd2,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,2'b10,1'b0}, // 10 R3 runs
    {2'd2,2'b00,2'b00,2'b01,2'b00,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b10,1'b0}, // 11 R4 left closed
    {2'd2,2'b01,2'b01,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 12 R7 stop wins
    {2'd2,2'b01,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b10,1'b0}, // 13 R1 start
    {2'd2,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,2'b10,1'b0}, // 14 R3 runs
    {2'd2,2'b00,2'b01,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 15 R1 fill stop
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 16 R9 enter manual
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,2'b11,1'b0}, // 17 R9 runs
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,2'b11,1'b0}, // 18 R5 short low
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,2'b11,1'b0}, // 19 R9 keeps running
    {2'd0,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 20 R9 off stops
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 21 R9 enter manual
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 22 R6 overload
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 23 R10 no restart
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 24 R6 reset ignored
    {2'd0,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 25 R6 off
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 26 R9 enter manual
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 27 R6 still tripped
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 28 R6 reset accepted
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,2'b11,1'b0}, // 29 R6 runs
    {2'd1,2'b01,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,2'b10,1'b0}, // 30 R1 fill in manual
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'b11,1'b0}, // 31 R2 power loss
    {2'd1,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}, // 32 R10 power back
    {2'd0,2'b00,2'b00,2'b01,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'b11,1'b0}  // 33 R9 off
  };
  localparam byte REQ [NV] = '{2,1,3,8,4,10,10,3,4,3,3,4,7,1,3,1,9,9,5,9,9,9,6,10,6,6,9,6,6,6,1,2,10,9};

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clk_step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick_pulse();
    @(negedge clk) tick = 1'b1;
    @(posedge clk);
    @(negedge clk) tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state
    check(2, "run after reset", {7'd0, pump_run}, 8'd0);
    check(2, "solenoids after reset", {6'd0, sol_energize}, 8'd3);
    check(8, "green lamp after reset", {7'd0, lamp_green}, 8'd1);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {mode_sel, fill_start, fill_stop, valve_open, valve_closed, level_high,
       suction_low, overload, starter_reset, ctrl_power_ok, seal_low} = VEC[v][20:4];
      clk_step();
      check(REQ[v], $sformatf("vec %0d run", v), {7'd0, pump_run}, {7'd0, VEC[v][3]});
      check(REQ[v], $sformatf("vec %0d sol", v), {6'd0, sol_energize}, {6'd0, VEC[v][2:1]});
      check(8, $sformatf("vec %0d seal alarm", v), {7'd0, seal_alarm}, {7'd0, VEC[v][0]});
      check(8, $sformatf("vec %0d lamps", v), {4'd0, lamp_high, lamp_red, lamp_green},
            {4'd0, VEC[v][10:9], VEC[v][3], ~VEC[v][3]});
    end

    // R5: suction window with a break, then a full window
    @(negedge clk) begin
      fill_start = 2'b00; fill_stop = 2'b00; starter_reset = 1'b0;
      mode_sel = 2'b01;
    end
    clk_step();
    clk_step();
    check(9, "manual run before suction test", {7'd0, pump_run}, 8'd1);
    @(negedge clk) suction_low = 1'b1;
    for (int k = 0; k < 4; k++) tick_pulse();
    clk_step();
    check(5, "four ticks low keeps running", {7'd0, pump_run}, 8'd1);
    @(negedge clk) suction_low = 1'b0;
    @(negedge clk) suction_low = 1'b1;
    for (int k = 0; k < 4; k++) tick_pulse();
    clk_step();
    check(5, "broken window keeps running", {7'd0, pump_run}, 8'd1);
    tick_pulse();
    clk_step();
    check(5, "full window trips", {7'd0, pump_run}, 8'd0);
    @(negedge clk) suction_low = 1'b0;
    clk_step();
    clk_step();
    check(10, "no restart after suction recovers", {7'd0, pump_run}, 8'd0);

    // R5: trip also holds in automatic mode
    @(negedge clk) begin
      mode_sel = 2'b10; fill_start = 2'b10;
      valve_open = 2'b10; valve_closed = 2'b01;
    end
    @(negedge clk) fill_start = 2'b00;
    clk_step();
    check(3, "auto run on tank 1", {7'd0, pump_run}, 8'd1);
    @(negedge clk) suction_low = 1'b1;
    for (int k = 0; k < 5; k++) tick_pulse();
    clk_step();
    check(5, "auto suction trip", {7'd0, pump_run}, 8'd0);

    @(negedge clk) begin suction_low = 1'b0; mode_sel = 2'b00; end
    clk_step();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule